// File: doc/BRIEF.md
# SPI hold pause controller

This block sits between the pins of a serial peripheral interface target and its command engine and implements the hold (pause) input. A system clock, faster than the serial clock, samples chip select, serial clock, serial data in and the active-low hold input through synchroniser chains. The block then turns the synchronised serial clock into one-cycle enables for its rising and falling edges. The command engine shifts and counts bits only on those enables. A pause therefore freezes the engine's bit counters and shift registers in place, and the transfer continues from the exact bit where it stopped once the pause ends.

Entering and leaving the pause are recognised only while the synchronised serial clock is low. A hold change seen while the clock is high takes effect at the next falling clock edge. The serial-out enable does not wait for any of this. It is gated directly by the raw hold pin, so the output floats the moment hold falls and drives again the moment hold rises. A rise of chip select ends the frame and clears the pause. Command decoding and all other chip-select handling belong to the engine.

Top module: `spi_hold_gate`

## Requirements
- R1: Outside a pause, every rising edge of the synchronised serial clock gives exactly one single-cycle pulse on `sck_rise_en`, and every falling edge gives one on `sck_fall_en`. `si_gated` follows the synchronised serial input.
- R2: When hold is low (0) while the synchronised serial clock is low and chip select is low, the pause is entered on the next system clock.
- R3: A hold fall seen while the serial clock is high does not enter the pause until the next falling serial clock edge. If hold returns high before that edge, no pause happens and that falling edge is passed on.
- R4: When hold is high (1) while the serial clock is low, the pause ends on the next system clock, and later serial clock edges are passed on again, so the transfer resumes where it stopped.
- R5: A hold rise seen while the serial clock is high ends the pause only at the next falling serial clock edge.
- R6: During a pause, neither edge enable pulses, and `si_gated` keeps the value it had just before the pause started, whatever the serial input does.
- R7: A serial clock edge in the system clock cycle where a deferred entry or exit takes effect is swallowed: no enable pulse for it.
- R8: `so_oe` is the engine's output enable ANDed with the raw hold pin. It reacts combinationally, with no system clock and regardless of the serial clock.
- R9: Chip select high (1) clears the pause, so a new frame starts unpaused.
- R10: After reset, both edge enables and `si_gated` are 0 and the block is not paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select pin, active low |
| sck | input | 1 | Serial clock pin |
| si | input | 1 | Serial data in pin |
| hold_n | input | 1 | Hold (pause) pin, active low |
| eng_so_en | input | 1 | Serial-out enable from the command engine |
| sck_rise_en | output | 1 | One-cycle enable for a passed rising serial clock edge |
| sck_fall_en | output | 1 | One-cycle enable for a passed falling serial clock edge |
| si_gated | output | 1 | Synchronised serial input, frozen during a pause |
| so_oe | output | 1 | Final serial-out enable toward the pin driver |

## Verification
The bench builds the block with its default values. These are a two-flop synchroniser chain and the frozen-input variant of the gated serial input. With two stages, every pin change reaches the pause logic in a fixed and short number of system cycles, so the bench can place hold changes deliberately inside the high or the low phase of the serial clock. That placement lets it tell an immediate entry or exit from a deferred one. It also exposes the swallowed boundary edge and shows the pause being cleared when chip select rises in the middle of a clock-high phase.

// File: rtl/hold_pause_pkg.sv
package hold_pause_pkg;

   typedef enum logic {
      ST_RUN   = 1'b0,
      ST_PAUSE = 1'b1
   } pause_st_e;

   // bit positions inside the synchronised pin vector
   localparam int PIN_CS   = 0;
   localparam int PIN_SCK  = 1;
   localparam int PIN_HOLD = 2;
   localparam int PIN_SI   = 3;
   localparam int NUM_PINS = 4;

   // idle levels: chip select and hold inactive (high), clock and data low
   localparam logic [NUM_PINS-1:0] PIN_IDLE = 4'b0101;

endpackage

// File: rtl/hold_pause_sync.sv
module hold_pause_sync #(
   parameter int                 WIDTH   = 4,
   parameter int                 STAGES  = 2,
   parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hold_pause_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("hold_pause_sync: WIDTH must be at least 1");
      end
   endgenerate

   genvar b;
   generate
      for (b = 0; b < WIDTH; b++) begin : g_bit
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
            else        chain_q <= {chain_q[STAGES-2:0], din[b]};
         end
         assign dout[b] = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/hold_pause_edge.sv
module hold_pause_edge #(
   parameter int               WIDTH   = 1,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl,
   output logic [WIDTH-1:0] rise,
   output logic [WIDTH-1:0] fall
);

   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;
   assign fall = ~lvl & prev_q;

endmodule

// File: rtl/hold_pause_fsm.sv
module hold_pause_fsm
   import hold_pause_pkg::*;
#(
   parameter bit   FREEZE_SI = 1'b1,
   parameter logic IDLE_SI   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_lvl,
   input  logic sck_lvl,
   input  logic hold_lvl,
   input  logic si_lvl,
   input  logic sck_rise,
   input  logic sck_fall,
   output logic rise_en,
   output logic fall_en,
   output logic si_gated,
   output logic pause_q
);

   pause_st_e st_q, st_d;
   logic      run_both;

   // pause decisions are taken only while the serial clock is low;
   // a deselected frame always drops the pause
   always_comb begin
      st_d = st_q;
      if (cs_lvl)        st_d = ST_RUN;
      else if (!sck_lvl) st_d = hold_lvl ? ST_RUN : ST_PAUSE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_RUN;
      else        st_q <= st_d;
   end

   // an edge counts only if running before and after this cycle's update
   assign run_both = (st_q == ST_RUN) && (st_d == ST_RUN);
   assign rise_en  = sck_rise & run_both;
   assign fall_en  = sck_fall & run_both;
   assign pause_q  = (st_q == ST_PAUSE);

   generate
      if (FREEZE_SI) begin : g_si_freeze
         logic si_frz_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        si_frz_q <= 1'b0;
            else if (run_both) si_frz_q <= si_lvl;
         end
         assign si_gated = run_both ? si_lvl : si_frz_q;
      end else begin : g_si_idle
         assign si_gated = run_both ? si_lvl : IDLE_SI;
      end
   endgenerate

endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate
   import hold_pause_pkg::*;
#(
   parameter int   SYNC_STAGES = 2,
   parameter bit   FREEZE_SI   = 1'b1,
   parameter logic IDLE_SI     = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sck,
   input  logic si,
   input  logic hold_n,
   input  logic eng_so_en,
   output logic sck_rise_en,
   output logic sck_fall_en,
   output logic si_gated,
   output logic so_oe
);

   logic [NUM_PINS-1:0] pins_raw;
   logic [NUM_PINS-1:0] pins_sync;
   logic                sync_cs, sync_sck, sync_hold, sync_si;
   logic                sck_rise, sck_fall;
   logic                pause_q;

   always_comb begin
      pins_raw           = '0;
      pins_raw[PIN_CS]   = cs_n;
      pins_raw[PIN_SCK]  = sck;
      pins_raw[PIN_HOLD] = hold_n;
      pins_raw[PIN_SI]   = si;
   end

   hold_pause_sync #(
      .WIDTH   (NUM_PINS),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pins_raw),
      .dout  (pins_sync)
   );

   assign sync_cs   = pins_sync[PIN_CS];
   assign sync_sck  = pins_sync[PIN_SCK];
   assign sync_hold = pins_sync[PIN_HOLD];
   assign sync_si   = pins_sync[PIN_SI];

   hold_pause_edge #(
      .WIDTH   (1),
      .RST_VAL (PIN_IDLE[PIN_SCK])
   ) u_sck_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (sync_sck),
      .rise  (sck_rise),
      .fall  (sck_fall)
   );

   hold_pause_fsm #(
      .FREEZE_SI (FREEZE_SI),
      .IDLE_SI   (IDLE_SI)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_lvl   (sync_cs),
      .sck_lvl  (sync_sck),
      .hold_lvl (sync_hold),
      .si_lvl   (sync_si),
      .sck_rise (sck_rise),
      .sck_fall (sck_fall),
      .rise_en  (sck_rise_en),
      .fall_en  (sck_fall_en),
      .si_gated (si_gated),
      .pause_q  (pause_q)
   );

   // output float follows the raw pin with no clock in the path
   assign so_oe = eng_so_en & hold_n;

endmodule

// File: rtl/spi_hold_gate_chk.sv
module spi_hold_gate_chk (
   input logic clk,
   input logic rst_n,
   input logic sync_cs,
   input logic sync_sck,
   input logic sync_hold,
   input logic pause_q,
   input logic sck_rise_en,
   input logic sck_fall_en,
   input logic hold_n,
   input logic so_oe
);

   a_r1_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sck_rise_en, sck_fall_en}));

   a_r2_enter_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_cs && !sync_sck && !sync_hold) |=> pause_q);

   a_r4_exit_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_cs && !sync_sck && sync_hold) |=> !pause_q);

   // R3 and R5: no pause change while the clock is high
   a_r5_defer_high: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_cs && sync_sck) |=> $stable(pause_q));

   a_r6_no_edges: assert property (@(posedge clk) disable iff (!rst_n)
      pause_q |-> !(sck_rise_en || sck_fall_en));

   a_r9_cs_clear: assert property (@(posedge clk) disable iff (!rst_n)
      sync_cs |=> !pause_q);

   always_comb begin
      if (rst_n) begin
         a_r8_float_on_hold: assert (hold_n || !so_oe);
      end
   end

endmodule

bind spi_hold_gate spi_hold_gate_chk chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .sync_cs     (sync_cs),
   .sync_sck    (sync_sck),
   .sync_hold   (sync_hold),
   .pause_q     (pause_q),
   .sck_rise_en (sck_rise_en),
   .sck_fall_en (sck_fall_en),
   .hold_n      (hold_n),
   .so_oe       (so_oe)
);

// File: tb/spi_hold_gate_tb_top.sv
`timescale 1ns/1ps
module spi_hold_gate_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, eng_so_en = 1'b0;
   logic sck_rise_en, sck_fall_en, si_gated, so_oe;

   int n_chk = 0, n_bad = 0;
   int rise_cnt = 0, fall_cnt = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   spi_hold_gate dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_n        (cs_n),
      .sck         (sck),
      .si          (si),
      .hold_n      (hold_n),
      .eng_so_en   (eng_so_en),
      .sck_rise_en (sck_rise_en),
      .sck_fall_en (sck_fall_en),
      .si_gated    (si_gated),
      .so_oe       (so_oe)
   );

   always @(negedge clk) begin
      if (sck_rise_en) rise_cnt++;
      if (sck_fall_en) fall_cnt++;
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      repeat (6) @(negedge clk);
   endtask

   task automatic pulse();
      sck = 1'b1; step();
      sck = 1'b0; step();
   endtask

   task automatic clr();
      @(negedge clk);
      rise_cnt = 0; fall_cnt = 0;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R10 rise_en in reset", sck_rise_en, 0);
      chk("R10 fall_en in reset", sck_fall_en, 0);
      chk("R10 si_gated in reset", si_gated, 0);
      rst_n = 1'b1;
      step();
      chk("R10 no pulses after reset", rise_cnt + fall_cnt, 0);
   endtask

   task automatic t_normal();
      cs_n = 1'b0; step(); clr();
      for (int i = 0; i < 5; i++) pulse();
      chk("R1 rise count", rise_cnt, 5);
      chk("R1 fall count", fall_cnt, 5);
      si = 1'b1; step();
      chk("R1 si follows", si_gated, 1);
   endtask

   task automatic t_pause_low();
      eng_so_en = 1'b1; #1;
      chk("R8 so_oe driving", so_oe, 1);
      hold_n = 1'b0; #1;
      chk("R8 so_oe floats at once", so_oe, 0);
      step(); clr();
      si = 1'b0;
      for (int i = 0; i < 3; i++) pulse();
      chk("R2 R6 rise blocked", rise_cnt, 0);
      chk("R2 R6 fall blocked", fall_cnt, 0);
      chk("R6 si frozen", si_gated, 1);
      hold_n = 1'b1; #1;
      chk("R8 so_oe back at once", so_oe, 1);
      step();
      chk("R4 si live again", si_gated, 0);
      clr();
      pulse(); pulse();
      chk("R4 rise resumes", rise_cnt, 2);
      chk("R4 fall resumes", fall_cnt, 2);
   endtask

   task automatic t_defer_enter();
      clr();
      sck = 1'b1; step();
      hold_n = 1'b0; step();
      hold_n = 1'b1; step();
      sck = 1'b0; step();
      chk("R3 cancelled entry keeps fall", fall_cnt, 1);
      sck = 1'b1; step();
      hold_n = 1'b0; step();
      sck = 1'b0; step();
      chk("R7 entry edge swallowed", fall_cnt, 1);
      pulse();
      chk("R3 paused after deferred entry rise", rise_cnt, 2);
      chk("R3 paused after deferred entry fall", fall_cnt, 1);
   endtask

   task automatic t_defer_exit();
      clr();
      sck = 1'b1; step();
      hold_n = 1'b1; step();
      sck = 1'b0; step();
      chk("R7 exit edge swallowed", rise_cnt + fall_cnt, 0);
      pulse();
      chk("R5 rise after deferred exit", rise_cnt, 1);
      chk("R5 fall after deferred exit", fall_cnt, 1);
   endtask

   task automatic t_cs_clear();
      hold_n = 1'b0; step(); clr();
      sck = 1'b1; step();
      cs_n = 1'b1; step();
      hold_n = 1'b1; step();
      cs_n = 1'b0; step();
      sck = 1'b0; step();
      chk("R9 rise while paused", rise_cnt, 0);
      chk("R9 cleared, fall passes", fall_cnt, 1);
   endtask

   initial begin
      t_reset();
      t_normal();
      t_pause_low();
      t_defer_enter();
      t_defer_exit();
      t_cs_clear();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule